// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware activity for profiling. It holds one free-running cycle counter and two event counters. Every clock it samples a vector of single-cycle event pulses. Each event counter watches one line of that vector, and an 8-bit code chooses the line. The cycle counter can advance on every clock, or once every 64 clocks when the prescaled mode is on.

Software reaches the block through a small register bus with four word addresses and a combinational read path. A single control word holds:
- the global enable;
- two one-shot counter resets;
- the prescale mode;
- three interrupt enables;
- three sticky overflow flags, each cleared by writing a one to it;
- the two event-select codes.

When a counter wraps past its all-ones value, its flag is set. A flag whose interrupt is enabled drives a registered level interrupt.

Top module: `evt_perf_mon`

## Requirements
- R1: After reset, all four registers read as zero and `irq` is low.
- R2: While the enable bit (control bit 0) is 0, no counter changes except through a bus write or a reset bit.
- R3: With enable set and the prescale bit (control bit 3) clear, the cycle counter (address 1) grows by exactly one per clock.
- R4: With enable and prescale both set, the cycle counter grows by exactly one per 64 clocks.
- R5: Event counter 0 (address 2) uses the select code in control bits 19:12. Event counter 1 (address 3) uses the code in bits 27:20. Each counter gains one in every enabled cycle in which the pulse line numbered by its code is high. A code of 0xFF, or any code at or above the number of event lines, counts nothing.
- R6: A control write with bit 1 set zeroes both event counters. A control write with bit 2 set zeroes the cycle counter. Both bits always read back as 0.
- R7: A bus write to a counter address loads that counter. The write takes priority over an increment in the same cycle.
- R8: When a counter wraps from all ones to 0, its overflow flag is set on the same edge. The flags are control bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter. A set flag stays set when another counter overflows.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R10: `irq` is high one cycle after any flag is set while its interrupt enable is set. The enables are control bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: Control bits 7, 11 and 31:28 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address: 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | EVT_LINES | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Registered level interrupt |

## Verification
The counting path is driven in three ways:
- Lone pulses on each selected line show that each counter follows only its own code.
- A pulse on both selected lines at once shows that the two counters run independently.
- A pulse on an unselected line, and all-ones pulse vectors under the null code and an out-of-range code, show that selection actually filters.

Cycle counting is measured as a difference over fixed windows, in plain mode and in prescaled mode, which separates the divide-by-64 path from the direct path. Wraps are forced by preloading counters near all ones. A wrap on a second counter while another flag is set shows that flags are kept. A selective write-one-to-clear shows that clearing is done per bit.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int WORD_W     = 32;
   localparam int NCNT       = 3;
   localparam int IDX_EV0    = 0;
   localparam int IDX_EV1    = 1;
   localparam int IDX_CYC    = 2;

   localparam int B_EN       = 0;
   localparam int B_CLR_EV   = 1;
   localparam int B_CLR_CYC  = 2;
   localparam int B_PSC      = 3;
   localparam int B_IE_LO    = 4;
   localparam int B_OVF_LO   = 8;
   localparam int B_SEL0_LO  = 12;
   localparam int B_SEL1_LO  = 20;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_CYC  = 2'd1,
      RA_EV0  = 2'd2,
      RA_EV1  = 2'd3
   } reg_addr_e;

   function automatic int cnt_of_addr(input logic [1:0] a);
      case (a)
         RA_CYC:  return IDX_CYC;
         RA_EV0:  return IDX_EV0;
         RA_EV1:  return IDX_EV1;
         default: return -1;
      endcase
   endfunction
endpackage

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_pow2
         assign tick = run && (&cnt);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else if (run) cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         assign tick = run && (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (tick) cnt <= '0;
            else if (run)  cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
   parameter int LINES = 32,
   parameter int SEL_W = 8
) (
   input  logic [LINES-1:0] pulses,
   input  logic [SEL_W-1:0] code,
   output logic             hit
);
   localparam int SPAN = 1 << SEL_W;

   logic [SPAN-1:0] padded;

   generate
      if (LINES >= SPAN) begin : g_trim
         assign padded = pulses[SPAN-1:0];
      end else begin : g_pad
         assign padded = {{(SPAN-LINES){1'b0}}, pulses};
      end
   endgenerate

   assign hit = padded[code];
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         wrap
);
   assign wrap = inc && !clr && !ld && (&q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (ld)  q <= ld_val;
      else if (inc) q <= q + 1'b1;
   end
endmodule

// File: rtl/evt_perf_mon.sv
module evt_perf_mon
   import pmu_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int EVT_LINES = 32,
   parameter int SEL_W     = 8,
   parameter int PRESCALE  = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_we,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [EVT_LINES-1:0] evt_pulse,
   output logic                 irq
);
   localparam int NEV = 2;

   generate
      if (CNT_W < 2 || CNT_W > WORD_W) begin : g_bad_w
         $error("CNT_W must lie in 2..32");
      end
      if (SEL_W != 8) begin : g_bad_sel
         $error("control word packs 8-bit select codes");
      end
      if (EVT_LINES < 1) begin : g_bad_lines
         $error("EVT_LINES must be positive");
      end
      if (PRESCALE < 2) begin : g_bad_psc
         $error("PRESCALE must be at least 2");
      end
   endgenerate

   // Control state
   logic             en_q, psc_q;
   logic [NCNT-1:0]  ie_q, ovf_q;
   logic [SEL_W-1:0] sel_q [NEV];

   logic wr_ctrl;
   logic clr_ev, clr_cyc;
   assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);
   assign clr_ev  = wr_ctrl && bus_wdata[B_CLR_EV];
   assign clr_cyc = wr_ctrl && bus_wdata[B_CLR_CYC];

   // Counter bank
   logic [NCNT-1:0][CNT_W-1:0] cnt_q;
   logic [NCNT-1:0]            inc, wrap, ld, clr;
   logic                       psc_tick;

   pmu_prescale #(.DIV(PRESCALE)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en_q && psc_q),
      .clr  (clr_cyc),
      .tick (psc_tick)
   );

   generate
      for (genvar e = 0; e < NEV; e++) begin : g_ev
         logic hit;
         pmu_evt_sel #(.LINES(EVT_LINES), .SEL_W(SEL_W)) u_sel (
            .pulses(evt_pulse),
            .code  (sel_q[e]),
            .hit   (hit)
         );
         assign inc[e] = en_q && hit;
         assign clr[e] = clr_ev;
      end
   endgenerate

   assign inc[IDX_CYC] = en_q && (!psc_q || psc_tick);
   assign clr[IDX_CYC] = clr_cyc;

   generate
      for (genvar c = 0; c < NCNT; c++) begin : g_cnt
         assign ld[c] = bus_we && (cnt_of_addr(bus_addr) == c);
         pmu_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr[c]),
            .ld    (ld[c]),
            .ld_val(bus_wdata[CNT_W-1:0]),
            .inc   (inc[c]),
            .q     (cnt_q[c]),
            .wrap  (wrap[c])
         );
      end
   endgenerate

   // Control register update; a wrap in the same cycle as a clear keeps the flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         psc_q <= 1'b0;
         ie_q  <= '0;
         ovf_q <= '0;
         for (int e = 0; e < NEV; e++) sel_q[e] <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q     <= bus_wdata[B_EN];
            psc_q    <= bus_wdata[B_PSC];
            ie_q     <= bus_wdata[B_IE_LO +: NCNT];
            sel_q[0] <= bus_wdata[B_SEL0_LO +: SEL_W];
            sel_q[1] <= bus_wdata[B_SEL1_LO +: SEL_W];
            ovf_q    <= (ovf_q & ~bus_wdata[B_OVF_LO +: NCNT]) | wrap;
         end else begin
            ovf_q    <= ovf_q | wrap;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(ovf_q & ie_q);
   end

   // Read path
   logic [31:0] ctrl_word;
   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[B_EN]                 = en_q;
      ctrl_word[B_PSC]                = psc_q;
      ctrl_word[B_IE_LO +: NCNT]      = ie_q;
      ctrl_word[B_OVF_LO +: NCNT]     = ovf_q;
      ctrl_word[B_SEL0_LO +: SEL_W]   = sel_q[0];
      ctrl_word[B_SEL1_LO +: SEL_W]   = sel_q[1];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == RA_CTRL) bus_rdata = ctrl_word;
      else                     bus_rdata[CNT_W-1:0] = cnt_q[cnt_of_addr(bus_addr)];
   end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
   import pmu_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 bus_addr,
   input logic                       bus_we,
   input logic [31:0]                bus_wdata,
   input logic [31:0]                bus_rdata,
   input logic                       en_q,
   input logic [NCNT-1:0]            ie_q,
   input logic [NCNT-1:0]            ovf_q,
   input logic [NCNT-1:0][CNT_W-1:0] cnt_q,
   input logic                       irq
);
   // R2: idle and disabled means frozen counters
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !bus_we) |=> $stable(cnt_q));

   // R10: interrupt follows masked flags by one cycle
   p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(ovf_q & ie_q))));

   // R11: reserved control bits read zero
   p_rsv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_CTRL) |-> (bus_rdata[31:28] == 4'h0 && !bus_rdata[11] && !bus_rdata[7]));

   for (genvar i = 0; i < NCNT; i++) begin : g_flag
      // R8: a flag only rises together with its counter reaching zero
      p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_q[i]) |-> (cnt_q[i] == '0));
      // R8/R9: a set flag survives anything but a write-one to it
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_q[i] && !(bus_we && bus_addr == RA_CTRL && bus_wdata[B_OVF_LO + i])) |=> ovf_q[i]);
   end
endmodule

bind evt_perf_mon pmu_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .en_q     (en_q),
   .ie_q     (ie_q),
   .ovf_q    (ovf_q),
   .cnt_q    (cnt_q),
   .irq      (irq)
);

// File: tb/sim_evt_perf_mon.sv
`timescale 1ns/1ps
module sim_evt_perf_mon;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] evt = '0;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   evt_perf_mon u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .evt_pulse(evt), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit en, input bit cev, input bit ccyc, input bit psc,
                                      input logic [2:0] ie, input logic [2:0] w1c,
                                      input logic [7:0] s0, input logic [7:0] s1);
      logic [31:0] w = '0;
      w[0] = en; w[1] = cev; w[2] = ccyc; w[3] = psc;
      w[6:4] = ie; w[10:8] = w1c; w[19:12] = s0; w[27:20] = s1;
      return w;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      addr = a; #1; v = rdata;
   endtask

   task automatic pulse(input logic [31:0] m);
      @(negedge clk); evt = m;
      @(negedge clk); evt = '0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reg reset", v, 32'h0); end
      chk("R1 irq reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_disabled;
      logic [31:0] v1, v2;
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b000, 8'h05, 8'h07));
      rd(1, v1);
      repeat (10) @(negedge clk);
      rd(1, v2);
      chk("R2 cycle frozen", v2, v1);
      pulse(32'h0000_00A0);
      rd(2, v1); chk("R2 ev0 frozen", v1, 32'h0);
   endtask

   task automatic t_cycle;
      logic [31:0] v1, v2;
      wr(0, mk(1, 0, 1, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
      rd(1, v1);
      repeat (20) @(negedge clk);
      rd(1, v2);
      chk("R3 cycle delta", v2 - v1, 32'd20);
   endtask

   task automatic t_prescale;
      logic [31:0] v1, v2;
      wr(0, mk(1, 0, 1, 1, 3'b000, 3'b000, 8'hFF, 8'hFF));
      rd(1, v1);
      repeat (640) @(negedge clk);
      rd(1, v2);
      chk("R4 prescaled delta", v2 - v1, 32'd10);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
   endtask

   task automatic t_events;
      logic [31:0] v;
      wr(0, mk(1, 1, 0, 0, 3'b000, 3'b000, 8'h05, 8'h07));
      pulse(32'h20); pulse(32'h80); pulse(32'hA0); pulse(32'h40); pulse(32'h80);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b000, 8'h05, 8'h07));
      rd(2, v); chk("R5 ev0 code 05", v, 32'd2);
      rd(3, v); chk("R5 ev1 code 07", v, 32'd3);
      wr(0, mk(1, 1, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h20));
      repeat (3) pulse(32'hFFFF_FFFF);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h20));
      rd(2, v); chk("R5 code FF counts nothing", v, 32'd0);
      rd(3, v); chk("R5 out-of-range code counts nothing", v, 32'd0);
   endtask

   task automatic t_resets;
      logic [31:0] v;
      wr(1, 32'd789); wr(2, 32'd123); wr(3, 32'd456);
      rd(2, v); chk("R7 load ev0", v, 32'd123);
      wr(0, mk(0, 1, 0, 0, 3'b000, 3'b000, 8'h00, 8'h00));
      rd(2, v); chk("R6 ev0 cleared", v, 32'd0);
      rd(3, v); chk("R6 ev1 cleared", v, 32'd0);
      rd(1, v); chk("R6 cycle untouched", v, 32'd789);
      rd(0, v); chk("R6 reset bits read 0", v & 32'h6, 32'h0);
      wr(0, mk(0, 0, 1, 0, 3'b000, 3'b000, 8'h00, 8'h00));
      rd(1, v); chk("R6 cycle cleared", v, 32'd0);
   endtask

   task automatic t_write_wins;
      logic [31:0] v;
      wr(0, mk(1, 0, 0, 0, 3'b000, 3'b000, 8'h05, 8'hFF));
      @(negedge clk); addr = 2; wdata = 32'h1000; we = 1'b1; evt = 32'h20;
      @(negedge clk); we = 1'b0; evt = '0;
      rd(2, v); chk("R7 write beats event", v, 32'h1000);
      wr(1, 32'hABCD);
      rd(1, v); chk("R7 write beats cycle", v, 32'hABCD);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b111, 8'h05, 8'hFF));
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(2, 32'hFFFF_FFFF);
      wr(0, mk(1, 0, 0, 0, 3'b001, 3'b000, 8'h05, 8'hFF));
      @(negedge clk); evt = 32'h20;
      @(negedge clk); evt = '0;
      rd(2, v); chk("R8 ev0 wrapped", v, 32'h0);
      rd(0, v); chk("R8 flag same edge", v[10:8], 32'h1);
      chk("R10 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R10 irq raised", {31'b0, irq}, 32'h1);
      wr(2, 32'h5);
      chk("R10 irq still high", {31'b0, irq}, 32'h1);
      wr(1, 32'hFFFF_FFF0);
      repeat (20) @(negedge clk);
      rd(0, v); chk("R8 flags accumulate", v[10:8], 32'h5);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b001, 8'h05, 8'hFF));
      rd(0, v); chk("R9 clear one flag", v[10:8], 32'h4);
      @(negedge clk);
      chk("R10 irq drops with enable", {31'b0, irq}, 32'h0);
      wr(0, mk(0, 0, 0, 0, 3'b000, 3'b100, 8'h05, 8'hFF));
      rd(0, v); chk("R9 clear last flag", v[10:8], 32'h0);
   endtask

   task automatic t_reserved;
      logic [31:0] v;
      wr(0, 32'hFFFF_FFFF);
      rd(0, v); chk("R11 reserved bits", v, 32'h0FFF_F079);
      chk("R10 no flags no irq", {31'b0, irq}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_disabled;
      t_cycle;
      t_prescale;
      t_events;
      t_resets;
      t_write_wins;
      t_wrap;
      t_reserved;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule